// File: doc/BRIEF.md
# Chained Descriptor DMA Fetch Engine

This engine walks a list of 16-byte transfer descriptors held in system memory and turns each one into buffer-transfer requests for a data mover that feeds a card data FIFO. Every descriptor carries a control word, a word with two buffer sizes, and two address words. The second address word is either a second buffer address or, when the descriptor is linked, a pointer to the next descriptor. The engine reads a descriptor one word at a time through a simple memory request port. It issues up to two buffer requests, then writes the control word back with the ownership flag cleared, which returns the descriptor to software.

Unlinked lists are laid out in memory at a fixed stride, which is 16 bytes plus a programmable number of skipped 32-bit words. A ring-end flag sends the walk back to the list base. When the engine reads a descriptor that software has not handed over, it parks in a suspended state and flags that no descriptor is available. A one-cycle poll strobe makes it read that same descriptor again. Sticky status flags, a bus error code, two summary bits and one interrupt line report progress to the host.

The memory request port and the buffer port are valid/ready. A request that is offered stays offered, with its address and direction unchanged, until ready is seen high at a clock edge. Memory responses have no back-pressure: the engine takes one response, flagged by a valid pulse, in any cycle after the request was accepted. All other pins are plain levels or one-cycle strobes.

Top module: `desc_chain_dma`

## Requirements
- R1: Once enabled from idle, the engine loads the current descriptor address from the base address. It reads the word at the current address first (the control word). If that word has bit 31 set (owned by the engine), it reads the words at current+4, +8 and +12, in that order, one read request per word.
- R2: If the control word has bit 31 clear, the engine reads no more words and enters the suspended state (st_fsm = 7). It sets the descriptor-unavailable flag (st_flags bit 3) and issues no memory or buffer requests while suspended.
- R3: A one-cycle poll_demand while suspended makes the engine read the control word again at the same current descriptor address.
- R4: Word 1 holds size 1 in bits 12:0 and size 2 in bits 25:13. The engine offers buffer 1 (address from word 2) and then buffer 2 (address from word 3). Any buffer whose size is zero is skipped, and buffer 2 is never offered when control bit 4 (linked) is set. buf_to_card follows cfg_to_card.
- R5: A buffer size above 4096 is offered with buf_len = 4096. No buffer request ever has a length of zero.
- R6: After the buffers, the engine writes the control word back to the current address. Bit 31 is cleared, bit 30 is set if card_err pulsed while that descriptor's buffers were being offered, and all other bits are unchanged.
- R7: After a good write-back the next address is word 3 when bit 4 is set. Otherwise it is the base address when bit 5 (ring end) is set. Otherwise it is current + 16 + 4 × cfg_skip_words. cur_desc_addr shows the current address.
- R8: On a good write-back of a descriptor with bit 2 (last) set and bit 1 (completion-interrupt disable) clear, the engine sets st_flags bit 0 (transmit done) if cfg_to_card is 1, or bit 1 (receive done) if it is 0.
- R9: An error on any memory response sets st_flags bit 2 and loads st_err_code: 1 for a descriptor read, 2 for a write-back. The engine then halts (st_fsm = 8) and issues no requests until soft reset.
- R10: st_norm_sum is the OR of the flags in bits 1:0 that have their int_en bit set. st_abn_sum is the same over bits 4:2. irq is (st_norm_sum and norm_en) or (st_abn_sum and abn_en).
- R11: cfg_soft_reset returns the engine to idle (st_fsm = 0) and clears all flags, the error code and cur_desc_addr. While cfg_enable is low, no memory or buffer request is offered.
- R12: Each flag stays set until a status_clr strobe on its bit position clears it. A new event in the same cycle wins over the clear.
- R13: A memory or buffer request that is offered and not accepted keeps its address (and direction or length) in the next cycle. It is still offered unless cfg_enable has dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Gates all request activity |
| cfg_soft_reset | input | 1 | Synchronous return to idle, clears status |
| cfg_to_card | input | 1 | 1: transfers go to the card, 0: from the card |
| cfg_base_addr | input | AW | Byte address of the first descriptor |
| cfg_skip_words | input | SKW | Words skipped between unlinked descriptors |
| poll_demand | input | 1 | Strobe that resumes a suspended walk |
| int_en | input | 5 | Per-flag interrupt enables |
| norm_en | input | 1 | Normal summary enable |
| abn_en | input | 1 | Abnormal summary enable |
| status_clr | input | 5 | Per-flag clear strobes |
| card_err | input | 1 | Card error strobe from the data path |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1: write-back, 0: descriptor read |
| mem_req_addr | output | AW | Byte address of the request |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Response carries a bus error |
| buf_valid | output | 1 | Buffer request offered |
| buf_ready | input | 1 | Buffer request accepted |
| buf_addr | output | AW | Buffer byte address |
| buf_len | output | LENW | Buffer length in bytes |
| buf_to_card | output | 1 | Transfer direction |
| cur_desc_addr | output | AW | Address of the descriptor in use |
| st_flags | output | 5 | Sticky flags: tx done, rx done, bus error, unavailable, card error |
| st_err_code | output | 3 | Bus error code |
| st_norm_sum | output | 1 | Enabled normal flags summary |
| st_abn_sum | output | 1 | Enabled abnormal flags summary |
| st_fsm | output | 4 | Walk state code |
| irq | output | 1 | Interrupt |

## Verification
The first read request is offered in the cycle after the enable edge is seen in idle. Each read word is then followed by the next request in the cycle after its response. Flags and the halted or suspended state code appear one edge after the response that causes them. The summary bits and irq follow the flags and enables combinationally. The bench never counts those cycles exactly: its memory and buffer models run half a clock after each edge under varying back-pressure. The main sequence waits on the state code with a bounded poll, then samples outputs at the falling edge. After any change to an enable it waits a short settling delay before reading the summaries.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;

  localparam int DESC_BYTES = 16;
  localparam int DESC_WORDS = 4;
  localparam int SIZE_W     = 13;

  // control-word bit positions
  localparam int F_NOIRQ   = 1;
  localparam int F_LAST    = 2;
  localparam int F_LINKED  = 4;
  localparam int F_RINGEND = 5;
  localparam int F_CARDERR = 30;
  localparam int F_OWN     = 31;

  // status flag positions
  localparam int NUM_FLAGS = 5;
  localparam int S_TX  = 0;
  localparam int S_RX  = 1;
  localparam int S_BUS = 2;
  localparam int S_DU  = 3;
  localparam int S_CE  = 4;
  localparam logic [NUM_FLAGS-1:0] NORMAL_MASK = 5'b00011;

  localparam logic [2:0] ERR_FETCH = 3'd1;
  localparam logic [2:0] ERR_WBACK = 3'd2;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_RD_REQ  = 4'd1,
    ST_RD_WAIT = 4'd2,
    ST_BUF1    = 4'd3,
    ST_BUF2    = 4'd4,
    ST_WB_REQ  = 4'd5,
    ST_WB_WAIT = 4'd6,
    ST_SUSPEND = 4'd7,
    ST_HALT    = 4'd8
  } walk_state_e;

endpackage

// File: rtl/desc_next_addr.sv
module desc_next_addr
  import desc_dma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SKW = 5
) (
  input  logic [AW-1:0]  cur_i,
  input  logic [AW-1:0]  base_i,
  input  logic [AW-1:0]  link_i,
  input  logic           linked_i,
  input  logic           ring_end_i,
  input  logic [SKW-1:0] skip_i,
  output logic [AW-1:0]  next_o
);

  logic [AW-1:0] stride;

  assign stride = AW'(DESC_BYTES) + (AW'(skip_i) << 2);

  always_comb begin
    if (linked_i)        next_o = link_i;
    else if (ring_end_i) next_o = base_i;
    else                 next_o = cur_i + stride;
  end

endmodule

// File: rtl/desc_irq_status.sv
module desc_irq_status
  import desc_dma_pkg::*;
#(
  parameter int NF = NUM_FLAGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic [2:0]    code_i,
  input  logic [NF-1:0] int_en_i,
  input  logic          norm_en_i,
  input  logic          abn_en_i,
  output logic [NF-1:0] flags_o,
  output logic [2:0]    code_o,
  output logic          norm_sum_o,
  output logic          abn_sum_o,
  output logic          irq_o
);

  logic [NF-1:0] enabled;

  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags_o[g] <= 1'b0;
      else if (soft_rst)  flags_o[g] <= 1'b0;
      else if (set_i[g])  flags_o[g] <= 1'b1;
      else if (clr_i[g])  flags_o[g] <= 1'b0;
    end

    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flags_o[g]);
    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[g] && !clr_i[g] && !soft_rst) |=> flags_o[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             code_o <= '0;
    else if (soft_rst)      code_o <= '0;
    else if (set_i[S_BUS])  code_o <= code_i;
  end

  assign enabled    = flags_o & int_en_i;
  assign norm_sum_o = |(enabled & NORMAL_MASK);
  assign abn_sum_o  = |(enabled & ~NORMAL_MASK);
  assign irq_o      = (norm_sum_o && norm_en_i) || (abn_sum_o && abn_en_i);

  a_r9_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    flags_o[S_BUS] |-> (code_o != 3'd0));

endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
  import desc_dma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int SKW     = 5,
  parameter int MAX_LEN = 4096,
  localparam int LENW   = $clog2(MAX_LEN) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_enable,
  input  logic                 cfg_soft_reset,
  input  logic                 cfg_to_card,
  input  logic [AW-1:0]        cfg_base_addr,
  input  logic [SKW-1:0]       cfg_skip_words,
  input  logic                 poll_demand,
  input  logic [NUM_FLAGS-1:0] int_en,
  input  logic                 norm_en,
  input  logic                 abn_en,
  input  logic [NUM_FLAGS-1:0] status_clr,
  input  logic                 card_err,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_write,
  output logic [AW-1:0]        mem_req_addr,
  output logic [31:0]          mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [31:0]          mem_rsp_data,
  input  logic                 mem_rsp_err,
  output logic                 buf_valid,
  input  logic                 buf_ready,
  output logic [AW-1:0]        buf_addr,
  output logic [LENW-1:0]      buf_len,
  output logic                 buf_to_card,
  output logic [AW-1:0]        cur_desc_addr,
  output logic [NUM_FLAGS-1:0] st_flags,
  output logic [2:0]           st_err_code,
  output logic                 st_norm_sum,
  output logic                 st_abn_sum,
  output logic [3:0]           st_fsm,
  output logic                 irq
);

  localparam int WIDXW = $clog2(DESC_WORDS);
  localparam logic [WIDXW-1:0] LAST_WORD = WIDXW'(DESC_WORDS - 1);

  walk_state_e      state;
  logic [AW-1:0]    cur_q;
  logic [31:0]      word_q [DESC_WORDS];
  logic [WIDXW-1:0] widx_q;
  logic             ce_q;

  logic             go;
  logic [LENW-1:0]  len1, len2;
  logic             skip1, skip2;
  logic             linked;
  logic [31:0]      wb_word;
  logic [AW-1:0]    next_addr;
  logic             rd_ok, wb_ok, rsp_bad;
  logic [NUM_FLAGS-1:0] flag_set;

  function automatic logic [LENW-1:0] clamp_len(input logic [SIZE_W-1:0] sz);
    if (int'(sz) > MAX_LEN) return LENW'(MAX_LEN);
    return LENW'(sz);
  endfunction

  assign go     = cfg_enable && !cfg_soft_reset;
  assign linked = word_q[0][F_LINKED];
  assign len1   = clamp_len(word_q[1][SIZE_W-1:0]);
  assign len2   = clamp_len(word_q[1][2*SIZE_W-1:SIZE_W]);
  assign skip1  = (len1 == '0);
  assign skip2  = linked || (len2 == '0);

  always_comb begin
    wb_word           = word_q[0];
    wb_word[F_OWN]    = 1'b0;
    wb_word[F_CARDERR] = word_q[0][F_CARDERR] | ce_q;
  end

  desc_next_addr #(.AW(AW), .SKW(SKW)) u_next (
    .cur_i      (cur_q),
    .base_i     (cfg_base_addr),
    .link_i     (word_q[3][AW-1:0]),
    .linked_i   (linked),
    .ring_end_i (word_q[0][F_RINGEND]),
    .skip_i     (cfg_skip_words),
    .next_o     (next_addr)
  );

  // request ports
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = cur_q + AW'({widx_q, 2'b00});
    mem_req_wdata = wb_word;
    buf_valid     = 1'b0;
    buf_addr      = word_q[2][AW-1:0];
    buf_len       = len1;
    unique case (state)
      ST_RD_REQ: mem_req_valid = go;
      ST_WB_REQ: begin
        mem_req_valid = go;
        mem_req_write = 1'b1;
        mem_req_addr  = cur_q;
      end
      ST_BUF1: buf_valid = go && !skip1;
      ST_BUF2: begin
        buf_valid = go && !skip2;
        buf_addr  = word_q[3][AW-1:0];
        buf_len   = len2;
      end
      default: ;
    endcase
  end

  assign buf_to_card = cfg_to_card;

  // response classification
  assign rsp_bad = mem_rsp_valid && mem_rsp_err &&
                   (state == ST_RD_WAIT || state == ST_WB_WAIT);
  assign rd_ok   = mem_rsp_valid && !mem_rsp_err && (state == ST_RD_WAIT);
  assign wb_ok   = mem_rsp_valid && !mem_rsp_err && (state == ST_WB_WAIT);

  always_comb begin
    flag_set        = '0;
    flag_set[S_BUS] = rsp_bad;
    flag_set[S_DU]  = rd_ok && (widx_q == '0) && !mem_rsp_data[F_OWN];
    if (wb_ok && word_q[0][F_LAST] && !word_q[0][F_NOIRQ]) begin
      flag_set[S_TX] = cfg_to_card;
      flag_set[S_RX] = !cfg_to_card;
    end
    flag_set[S_CE]  = wb_ok && wb_word[F_CARDERR];
  end

  // walk sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cur_q  <= '0;
      widx_q <= '0;
      ce_q   <= 1'b0;
      for (int i = 0; i < DESC_WORDS; i++) word_q[i] <= '0;
    end else if (cfg_soft_reset) begin
      state  <= ST_IDLE;
      cur_q  <= '0;
      widx_q <= '0;
      ce_q   <= 1'b0;
      for (int i = 0; i < DESC_WORDS; i++) word_q[i] <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (cfg_enable) begin
          cur_q  <= cfg_base_addr;
          widx_q <= '0;
          ce_q   <= 1'b0;
          state  <= ST_RD_REQ;
        end
        ST_RD_REQ: if (mem_req_valid && mem_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) state <= ST_HALT;
          else begin
            word_q[widx_q] <= mem_rsp_data;
            if (widx_q == '0 && !mem_rsp_data[F_OWN]) state <= ST_SUSPEND;
            else if (widx_q == LAST_WORD)             state <= ST_BUF1;
            else begin
              widx_q <= widx_q + 1'b1;
              state  <= ST_RD_REQ;
            end
          end
        end
        ST_BUF1: begin
          ce_q <= ce_q | card_err;
          if (skip1 || (buf_valid && buf_ready)) state <= ST_BUF2;
        end
        ST_BUF2: begin
          ce_q <= ce_q | card_err;
          if (skip2 || (buf_valid && buf_ready)) state <= ST_WB_REQ;
        end
        ST_WB_REQ: if (mem_req_valid && mem_req_ready) state <= ST_WB_WAIT;
        ST_WB_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) state <= ST_HALT;
          else begin
            cur_q  <= next_addr;
            widx_q <= '0;
            ce_q   <= 1'b0;
            state  <= ST_RD_REQ;
          end
        end
        ST_SUSPEND: if (poll_demand) begin
          widx_q <= '0;
          state  <= ST_RD_REQ;
        end
        ST_HALT: ;
        default: state <= ST_IDLE;
      endcase
    end
  end

  desc_irq_status #(.NF(NUM_FLAGS)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (cfg_soft_reset),
    .set_i      (flag_set),
    .clr_i      (status_clr),
    .code_i     ((state == ST_WB_WAIT) ? ERR_WBACK : ERR_FETCH),
    .int_en_i   (int_en),
    .norm_en_i  (norm_en),
    .abn_en_i   (abn_en),
    .flags_o    (st_flags),
    .code_o     (st_err_code),
    .norm_sum_o (st_norm_sum),
    .abn_sum_o  (st_abn_sum),
    .irq_o      (irq)
  );

  assign cur_desc_addr = cur_q;
  assign st_fsm        = state;

  // R13: offered requests hold until accepted
  a_r13_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !cfg_soft_reset) |=>
      ((mem_req_valid || !cfg_enable) && $stable(mem_req_addr) && $stable(mem_req_write)));
  a_r13_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !buf_ready && !cfg_soft_reset) |=>
      ((buf_valid || !cfg_enable) && $stable(buf_addr) && $stable(buf_len)));
  // R5: lengths stay in range
  a_r5_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> (buf_len != '0 && int'(buf_len) <= MAX_LEN));
  // R6: write-back always returns ownership
  a_r6_owner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> !mem_req_wdata[31]);
  // R9: halted engine stays halted and silent
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fsm == 4'd8 && !cfg_soft_reset) |=> (st_fsm == 4'd8));
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fsm == 4'd8) |-> (!mem_req_valid && !buf_valid));
  // R2: no traffic while parked
  a_r2_suspend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fsm == 4'd7) |-> (!mem_req_valid && !buf_valid));
  // R11: disabled engine offers nothing
  a_r11_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> (!mem_req_valid && !buf_valid));

endmodule

// File: tb/desc_chain_dma_test.sv
module desc_chain_dma_test;

  localparam logic [31:0] OWN = 32'h8000_0000, LINK = 32'h10, RING = 32'h20,
                          LAST = 32'h4, NOIRQ = 32'h2, FIRST = 32'h8, CERR = 32'h4000_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, cfg_enable, cfg_soft_reset, cfg_to_card, poll_demand;
  logic [31:0] cfg_base_addr;
  logic [4:0]  cfg_skip_words, int_en, status_clr, st_flags;
  logic        norm_en, abn_en, card_err;
  logic        mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_data, buf_addr, cur_desc_addr;
  logic        buf_valid, buf_ready, buf_to_card, st_norm_sum, st_abn_sum, irq;
  logic [12:0] buf_len;
  logic [2:0]  st_err_code;
  logic [3:0]  st_fsm;

  desc_chain_dma uut (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit done_f = 0;
  logic [31:0] mem [128];
  bit pend = 0, pend_we = 0, err_rd = 0, err_wr = 0, buf_hold = 0;
  logic [31:0] pend_a, pend_wd;
  int nreq = 0, nbuf = 0, nrd = 0;
  logic [31:0] buf_a_log [16], rd_log [16];
  int buf_l_log [16];

  // memory and buffer models, half a clock after each edge
  always begin
    @(negedge clk); #1;
    cyc++;
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
    if (pend) begin
      mem_rsp_valid = 1'b1;
      if (pend_we) begin
        mem_rsp_err = err_wr;
        if (!err_wr) mem[pend_a[8:2]] = pend_wd;
      end else begin
        mem_rsp_err  = err_rd;
        mem_rsp_data = mem[pend_a[8:2]];
      end
      pend = 0;
    end
    mem_req_ready = (cyc % 3) != 0;
    buf_ready     = !buf_hold && ((cyc % 4) != 1);
    #0;
    if (mem_req_valid && mem_req_ready) begin
      pend = 1; pend_we = mem_req_write; pend_a = mem_req_addr; pend_wd = mem_req_wdata;
      nreq++;
      if (!mem_req_write && nrd < 16) begin rd_log[nrd] = mem_req_addr; nrd++; end
    end
    if (buf_valid && buf_ready && nbuf < 16) begin
      buf_a_log[nbuf] = buf_addr; buf_l_log[nbuf] = int'(buf_len); nbuf++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_fsm(input logic [3:0] s, input string tag);
    int n = 0;
    while (st_fsm !== s && n < 3000) begin @(negedge clk); n++; end
    chk(tag, {28'd0, st_fsm}, {28'd0, s});
  endtask

  task automatic restart();
    cfg_enable = 0; cfg_soft_reset = 1;
    @(negedge clk);
    cfg_soft_reset = 0;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    nbuf = 0; nrd = 0; buf_hold = 0; err_rd = 0; err_wr = 0;
  endtask

  task automatic put_desc(input logic [31:0] a, ctl, input int s1, s2, input logic [31:0] b1, b3);
    mem[a[8:2]]       = ctl;
    mem[a[8:2] + 7'd1] = {6'd0, 13'(s2), 13'(s1)};
    mem[a[8:2] + 7'd2] = b1;
    mem[a[8:2] + 7'd3] = b3;
  endtask

  task automatic pulse_poll();
    poll_demand = 1; @(negedge clk); poll_demand = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_f) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] base, stride, ctl2, c0;
    int n0, b0;
    rst_n = 0; cfg_enable = 0; cfg_soft_reset = 0; cfg_to_card = 0; poll_demand = 0;
    cfg_base_addr = 32'h40; cfg_skip_words = 0; int_en = 0; norm_en = 0; abn_en = 0;
    status_clr = 0; card_err = 0;
    repeat (3) @(negedge clk);
    chk("reset R11 fsm", {28'd0, st_fsm}, 0);
    chk("reset R11 flags", {27'd0, st_flags}, 0);
    chk("reset R10 irq", {31'd0, irq}, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk("R11 disabled no requests", nreq, 0);
    chk("R11 disabled stays idle", {28'd0, st_fsm}, 0);

    // ring sweep over skip length and direction
    base = 32'h40;
    for (int skip = 0; skip < 4; skip++) begin
      for (int dir = 0; dir < 2; dir++) begin
        restart();
        stride = 16 + 4 * skip;
        cfg_skip_words = 5'(skip); cfg_to_card = dir[0];
        ctl2 = OWN | LAST | RING | ((skip == 3) ? NOIRQ : 0);
        put_desc(base, OWN | FIRST, 8 * (skip + 1), 0, 32'h1000, 32'h2000);
        put_desc(base + stride, OWN, 0, 5000, 32'h1100, 32'h2100);
        put_desc(base + 2 * stride, ctl2, 12 + skip, 20, 32'h1200, 32'h2200);
        int_en = 5'h1f; norm_en = 1; abn_en = 0;
        cfg_enable = 1;
        wait_fsm(4'd7, "R2 ring walk suspends");
        if (skip == 0 && dir == 0)
          for (int k = 0; k < 4; k++) chk("R1 fetch order", rd_log[k], base + 4 * k);
        chk("R4 buffer count", nbuf, 4);
        chk("R4 buf1 of d0", buf_a_log[0], 32'h1000);
        chk("R4 len of d0", buf_l_log[0], 8 * (skip + 1));
        chk("R5 clamped buf2 of d1", buf_a_log[1], 32'h2100);
        chk("R5 clamped len", buf_l_log[1], 4096);
        chk("R4 buf1 of d2", buf_l_log[2], 12 + skip);
        chk("R4 buf2 of d2", buf_a_log[3], 32'h2200);
        chk("R6 d0 written back", mem[base[8:2]], FIRST);
        chk("R6 d1 written back", mem[(base + stride) >> 2], 0);
        chk("R6 d2 written back", mem[(base + 2 * stride) >> 2], ctl2 & ~OWN);
        chk("R7 ring end returns to base", cur_desc_addr, base);
        chk("R8 done flags", {27'd0, st_flags},
            {27'd0, 5'b01000 | ((skip == 3) ? 5'd0 : (dir ? 5'd1 : 5'd2))});
        chk("R10 irq normal", {31'd0, irq}, (skip == 3) ? 0 : 1);
        chk("R10 abnormal summary", {31'd0, st_abn_sum}, 1);
      end
    end

    // still suspended: no traffic
    n0 = nreq; b0 = nbuf;
    repeat (20) @(negedge clk);
    chk("R2 no reads while suspended", nreq, n0);
    chk("R2 no buffers while suspended", nbuf, b0);
    // poll demand resumes at the same descriptor
    mem[base[8:2]] = mem[base[8:2]] | OWN;
    nbuf = 0;
    pulse_poll();
    repeat (3) @(negedge clk);
    wait_fsm(4'd7, "R3 poll resumes and resuspends");
    chk("R3 one buffer after poll", nbuf, 1);
    chk("R3 buffer len after poll", buf_l_log[0], 32);
    chk("R7 skip stride", cur_desc_addr, base + 28);

    // R12 clear all flags
    status_clr = 5'h1f; @(negedge clk); status_clr = 0;
    chk("R12 flags cleared", {27'd0, st_flags}, 0);
    chk("R12 irq cleared", {31'd0, irq}, 0);

    // linked list
    restart();
    cfg_to_card = 0; cfg_skip_words = 5'd7;
    put_desc(32'h40, OWN | LINK, 100, 200, 32'h3000, 32'h100);
    put_desc(32'h100, OWN | LINK, 0, 300, 32'h3100, 32'h80);
    put_desc(32'h80, OWN | LINK | RING | LAST, 4096, 7, 32'h3200, 32'h140);
    cfg_enable = 1;
    wait_fsm(4'd7, "R7 linked walk suspends");
    chk("R4 linked buffer count", nbuf, 2);
    chk("R4 linked first buf", buf_a_log[0], 32'h3000);
    chk("R4 linked second buf", buf_a_log[1], 32'h3200);
    chk("R5 exact max length", buf_l_log[1], 4096);
    chk("R7 link pointer followed", cur_desc_addr, 32'h140);
    chk("R8 receive done", {27'd0, st_flags}, {27'd0, 5'b01010});

    // card error write-back
    restart();
    cfg_skip_words = 0;
    put_desc(32'h40, OWN | LAST, 16, 0, 32'h4000, 0);
    buf_hold = 1;
    cfg_enable = 1;
    for (int i = 0; i < 200 && !buf_valid; i++) @(negedge clk);
    card_err = 1; @(negedge clk); card_err = 0;
    buf_hold = 0;
    wait_fsm(4'd7, "R6 card error run");
    chk("R6 card error flag written", mem[32'h40 >> 2], LAST | CERR);
    chk("R6 card error status", {31'd0, st_flags[4]}, 1);
    chk("R7 unlinked next", cur_desc_addr, 32'h50);
    int_en = 5'b00111; norm_en = 0; abn_en = 1; #1;
    chk("R10 masked flags no irq", {31'd0, irq}, 0);
    int_en = 5'b10000; #1;
    chk("R10 card error irq", {31'd0, irq}, 1);

    // bus error on fetch
    restart();
    put_desc(32'h40, OWN, 8, 0, 32'h5000, 0);
    err_rd = 1;
    cfg_enable = 1;
    wait_fsm(4'd8, "R9 fetch error halts");
    chk("R9 fetch error code", {29'd0, st_err_code}, 1);
    chk("R9 bus error flag", {31'd0, st_flags[2]}, 1);
    n0 = nreq;
    repeat (20) @(negedge clk);
    chk("R9 halted no requests", nreq, n0);

    // bus error on write-back
    restart();
    put_desc(32'h40, OWN, 8, 0, 32'h5000, 0);
    err_wr = 1;
    cfg_enable = 1;
    wait_fsm(4'd8, "R9 write-back error halts");
    chk("R9 write-back error code", {29'd0, st_err_code}, 2);

    // soft reset recovery
    c0 = cur_desc_addr;
    chk("R11 address before reset", c0, 32'h40);
    restart();
    chk("R11 soft reset fsm", {28'd0, st_fsm}, 0);
    chk("R11 soft reset flags", {27'd0, st_flags}, 0);
    chk("R11 soft reset code", {29'd0, st_err_code}, 0);
    chk("R11 soft reset address", cur_desc_addr, 0);

    done_f = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule